// File: doc/BRIEF.md
# Game of Life Cell-Serial Engine

This block evolves a Conway's Game of Life population on an 8-by-8 board. The board is held as a 64-bit vector: cell `r*8 + c` sits at bit `r*8 + c`. The vector is on the output at all times, so a display scanner can read it directly. A reset loads a fixed, parameterised seed population.

After that, each pulse on the generation strobe advances the board by exactly one generation. An external prescaler normally drives the strobe, so that generations advance at a rate a viewer can follow.

When a generation starts, the engine freezes a copy of the board. It then visits cells 0 to 63 in turn, spending two cycles on each. In the first cycle it counts the cell's eight neighbours from the frozen copy. In the second cycle it writes the cell's new value into the live board. Neighbours are found by index offsets taken modulo 64. The board therefore wraps at its top and bottom edges, and the left and right edges join onto the adjacent rows.

Top module: `life_engine`

## Requirements
- R1: While reset is low, `grid_o` equals the SEED parameter. The default seed is 64'h8100_0070_7007_0482. One cycle after reset is released, the engine is ready to accept a strobe.
- R2: While the engine is idle between generations and `step_i` is low, `grid_o` does not change, however long the wait.
- R3: A strobe that is high at a clock edge while the engine is idle starts a generation at that edge, E0. The new value of cell k appears on `grid_o` after edge E0+2+2k. No other bit changes during the generation.
- R4: The neighbour count of cell i sums the frozen cells at indices (i-9), (i-8), (i-7), (i-1), (i+1), (i+7), (i+8) and (i+9), each taken modulo 64. Cells already rewritten earlier in the same generation do not influence the count.
- R5: A live cell with fewer than 2 live neighbours becomes dead.
- R6: A live cell with more than 3 live neighbours becomes dead.
- R7: A dead cell with exactly 3 live neighbours becomes live.
- R8: Every other cell keeps its value: a live cell with 2 or 3 neighbours, and a dead cell with any count other than 3.
- R9: A strobe that arrives while a generation is in progress is ignored. The board advances by exactly one generation and then stays idle.
- R10: After cell 63 is written (edge E0+128), the engine is idle again. If the strobe is held high, the next generation starts at edge E0+129, so generations follow every 129 cycles.
- R11: The neighbour count register never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset; loads the seed |
| step_i | input | 1 | Generation-start strobe, sampled only while idle |
| grid_o | output | 64 | Current board, bit r*8+c is row r, column c |

## Verification
The hardest situation to reach is the board in mid-generation. At that point the low-numbered cells already hold next-generation values, while their high-numbered neighbours still need the old ones. A design that read the live board instead of the frozen copy would go wrong only here. The stimulus reaches this point by sampling the board at exact cycle offsets from the accepted strobe: after the first cell is written, and just before the last. The seed places a glider, a crowded 3-by-2 block and cells on the wrapping edges close enough to interact, so that every rule and the wrap arithmetic are exercised over several generations.

// File: rtl/life_pkg.sv
package life_pkg;

    // Control states of the cell-serial engine
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_FRAME = 2'd1,
        ST_SUM   = 2'd2,
        ST_APPLY = 2'd3
    } life_state_e;

    // Neighbourhood and rule constants
    localparam int NBR_CNT  = 8;
    localparam int LIVE_MIN = 2;
    localparam int LIVE_MAX = 3;
    localparam int BIRTH_N  = 3;
    localparam int SUM_W    = $clog2(NBR_CNT + 1);

endpackage

// File: rtl/life_nbr_count.sv
module life_nbr_count import life_pkg::*; #(
    parameter int ROW_LEN = 8,
    parameter int CELLS   = 64,
    localparam int IDX_W  = $clog2(CELLS)
) (
    input  logic [CELLS-1:0] snap_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [SUM_W-1:0] sum_o
);

    // 3x3 window, centre position excluded
    logic [8:0] hit;

    for (genvar k = 0; k < 9; k++) begin : g_win
        if (k == 4) begin : g_centre
            assign hit[k] = 1'b0;
        end else begin : g_nbr
            localparam int OFF = (k / 3 - 1) * ROW_LEN + (k % 3 - 1);
            logic [IDX_W-1:0] pos;
            assign pos    = IDX_W'((int'(idx_i) + CELLS + OFF) % CELLS);
            assign hit[k] = snap_i[pos];
        end
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < 9; k++) begin
            sum_o = sum_o + SUM_W'(hit[k]);
        end
    end

endmodule

// File: rtl/life_rule.sv
module life_rule import life_pkg::*; (
    input  logic             alive_i,
    input  logic [SUM_W-1:0] sum_i,
    output logic             next_o
);

    logic keep;
    logic born;

    assign keep   = (sum_i >= SUM_W'(LIVE_MIN)) && (sum_i <= SUM_W'(LIVE_MAX));
    assign born   = (sum_i == SUM_W'(BIRTH_N));
    assign next_o = alive_i ? keep : born;

endmodule

// File: rtl/life_engine.sv
module life_engine import life_pkg::*; #(
    parameter int ROW_LEN  = 8,
    parameter int NUM_ROWS = 8,
    parameter logic [ROW_LEN*NUM_ROWS-1:0] SEED = 64'h8100_0070_7007_0482
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         step_i,
    output logic [ROW_LEN*NUM_ROWS-1:0]  grid_o
);

    localparam int CELLS = ROW_LEN * NUM_ROWS;
    localparam int IDX_W = $clog2(CELLS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

    typedef struct packed {
        life_state_e       state;
        logic [CELLS-1:0]  grid;
        logic [CELLS-1:0]  snap;
        logic [IDX_W-1:0]  idx;
        logic [SUM_W-1:0]  sum;
    } life_regs_t;

    localparam life_regs_t RESET_VAL = '{
        state: ST_START,
        grid:  SEED,
        snap:  '0,
        idx:   '0,
        sum:   '0
    };

    life_regs_t r_d, r_q;

    logic [SUM_W-1:0] nbr_sum;
    logic             cell_next;

    life_nbr_count #(
        .ROW_LEN (ROW_LEN),
        .CELLS   (CELLS)
    ) i_count (
        .snap_i (r_q.snap),
        .idx_i  (r_q.idx),
        .sum_o  (nbr_sum)
    );

    life_rule i_rule (
        .alive_i (r_q.grid[r_q.idx]),
        .sum_i   (r_q.sum),
        .next_o  (cell_next)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_START: begin
                r_d.state = ST_FRAME;
            end
            ST_FRAME: begin
                if (step_i) begin
                    r_d.snap  = r_q.grid;
                    r_d.idx   = '0;
                    r_d.state = ST_SUM;
                end
            end
            ST_SUM: begin
                r_d.sum   = nbr_sum;
                r_d.state = ST_APPLY;
            end
            ST_APPLY: begin
                r_d.grid[r_q.idx] = cell_next;
                r_d.idx           = r_q.idx + 1'b1;
                if (r_q.idx == LAST_IDX) begin
                    r_d.state = ST_FRAME;
                end else begin
                    r_d.sum   = '0;
                    r_d.state = ST_SUM;
                end
            end
            default: r_d.state = ST_START;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign grid_o = r_q.grid;

endmodule

// File: rtl/life_engine_chk.sv
module life_engine_chk import life_pkg::*; #(
    parameter int CELLS = 64,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [CELLS-1:0] grid_o,
    input  life_state_e      state_q,
    input  logic [IDX_W-1:0] idx_q,
    input  logic [SUM_W-1:0] sum_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

    // R1
    start_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_START |=> state_q == ST_FRAME);

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FRAME && !step_i) |=> $stable(grid_o));

    // R3
    gen_begin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FRAME && step_i) |=> (state_q == ST_SUM && idx_q == '0));

    // R3
    count_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_SUM |=> (state_q == ST_APPLY && $stable(grid_o)));

    // R3
    one_cell_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_APPLY |=>
            ((grid_o ^ $past(grid_o)) & ~({{(CELLS-1){1'b0}}, 1'b1} << $past(idx_q))) == '0);

    // R9
    ignore_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_APPLY && idx_q != LAST_IDX) |=>
            (state_q == ST_SUM && idx_q == $past(idx_q) + 1'b1));

    // R10
    gen_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_APPLY && idx_q == LAST_IDX) |=> state_q == ST_FRAME);

    // R11
    sum_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sum_q <= SUM_W'(NBR_CNT));

endmodule

bind life_engine life_engine_chk #(
    .CELLS (CELLS)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .grid_o  (grid_o),
    .state_q (r_q.state),
    .idx_q   (r_q.idx),
    .sum_q   (r_q.sum)
);

// File: tb/test_life_engine.sv
module test_life_engine;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] SEED = 64'h8100_0070_7007_0482;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        step_i = 1'b0;
    logic [63:0] grid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    life_engine #(.SEED(SEED)) i_life_engine (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step_i),
        .grid_o (grid_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    // Reference model of one generation (R4..R8)
    function automatic int nbr(input logic [63:0] g, input int i);
        int s = 0;
        int offs [8] = '{-9, -8, -7, -1, 1, 7, 8, 9};
        foreach (offs[k]) s += int'(g[(i + 64 + offs[k]) % 64]);
        return s;
    endfunction

    function automatic logic [63:0] next_gen(input logic [63:0] g);
        logic [63:0] n;
        for (int i = 0; i < 64; i++) begin
            int s = nbr(g, i);
            n[i] = g[i] ? (s == 2 || s == 3) : (s == 3);
        end
        return n;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Per-cell check, tagged with the rule that applies
    task automatic chk_cells(input logic [63:0] old_g);
        logic [63:0] exp_g = next_gen(old_g);
        for (int i = 0; i < 64; i++) begin
            int s = nbr(old_g, i);
            string tag;
            if (old_g[i] && s < 2)        tag = "R5 underpopulated";
            else if (old_g[i] && s > 3)   tag = "R6 overcrowded";
            else if (!old_g[i] && s == 3) tag = "R7 birth";
            else                          tag = "R8 unchanged";
            chk(grid_o[i] == exp_g[i], $sformatf("%s cell %0d", tag, i),
                64'(grid_o[i]), 64'(exp_g[i]));
        end
        chk(grid_o == exp_g, "R4 full board with wrap", grid_o, exp_g);
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        step_i = 1'b0;
        repeat (3) @(negedge clk_i);
        chk(grid_o == SEED, "R1 seed in reset", grid_o, SEED);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk(grid_o == SEED, "R1 seed after release", grid_o, SEED);
    endtask

    task automatic t_idle();
        logic [63:0] g = grid_o;
        repeat (300) @(negedge clk_i);
        chk(grid_o == g, "R2 idle without strobe", grid_o, g);
    endtask

    // One strobe, with timing of first and last cell writes (R3)
    task automatic t_generation();
        logic [63:0] old_g = grid_o;
        logic [63:0] nxt = next_gen(old_g);
        logic [63:0] e;
        step_i = 1'b1;
        @(negedge clk_i);            // edge E0 has taken the strobe
        step_i = 1'b0;
        @(negedge clk_i);            // after E0+1
        chk(grid_o == old_g, "R3 no write at E0+1", grid_o, old_g);
        @(negedge clk_i);            // after E0+2
        e = {old_g[63:1], nxt[0]};
        chk(grid_o == e, "R3 cell 0 at E0+2", grid_o, e);
        repeat (125) @(negedge clk_i); // after E0+127
        e = {old_g[63], nxt[62:0]};
        chk(grid_o == e, "R3 cell 63 pending at E0+127", grid_o, e);
        @(negedge clk_i);            // after E0+128
        chk_cells(old_g);
    endtask

    task automatic t_ignored();
        logic [63:0] old_g = grid_o;
        logic [63:0] e = next_gen(old_g);
        step_i = 1'b1;
        @(negedge clk_i);
        step_i = 1'b0;
        repeat (40) @(negedge clk_i);
        step_i = 1'b1;
        repeat (3) @(negedge clk_i);
        step_i = 1'b0;
        repeat (250) @(negedge clk_i);
        chk(grid_o == e, "R9 mid-generation strobe ignored", grid_o, e);
    endtask

    task automatic t_held();
        logic [63:0] g0 = grid_o;
        logic [63:0] g1 = next_gen(g0);
        logic [63:0] g2 = next_gen(g1);
        logic [63:0] e;
        step_i = 1'b1;
        @(negedge clk_i);            // E0
        repeat (128) @(negedge clk_i); // after E0+128
        chk(grid_o == g1, "R10 first generation done", grid_o, g1);
        repeat (2) @(negedge clk_i); // after E0+130, second generation running
        step_i = 1'b0;
        repeat (126) @(negedge clk_i); // after E0+256
        e = {g1[63], g2[62:0]};
        chk(grid_o == e, "R10 back-to-back cell 63 pending", grid_o, e);
        @(negedge clk_i);            // after E0+257
        chk(grid_o == g2, "R10 back-to-back generation", grid_o, g2);
        repeat (200) @(negedge clk_i);
        chk(grid_o == g2, "R10 idle after release", grid_o, g2);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_generation();
        t_generation();
        t_idle();
        t_ignored();
        t_generation();
        t_held();
        t_generation();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule